// File: doc/BRIEF.md
# Comma-Aligned Deserializer with Dual Byte Clocks

This block sits behind a clock-and-data-recovery front end. It takes one retimed serial bit per bit-clock cycle and rebuilds 10-bit words. The first bit to arrive becomes bit 0 of the word. The block searches the stream for the positive-disparity comma. Once it finds one, it sets the word boundary so that commas leave on the rising edge of byte clock 1, and the words in between leave on byte clock 0.

Byte clocks 0 and 1 are complementary levels, and each runs at half the word rate. A single-cycle `rx_valid` pulse marks each presented word in the same cycle that one of the byte clocks rises. When alignment moves, the level that is currently high is held longer, so no half period is ever shorter than one word time. The source is a serial line and cannot be stalled, so the output has no ready input and no back-pressure: the consumer must take every word in the cycle that `rx_valid` is high.

`align_en` gates the whole alignment function. When `align_en` is low, commas are ignored. When `sig_present` is low, the word output reads all ones.

Top module: `comma_align_deser`

## Requirements
- R1: Bit order. The first bit received lands in `rx_word[0]` and the tenth lands in `rx_word[9]`. Each presented word is the ten bits that arrived since the previous word boundary.
- R2: Comma recognition. A comma is a window whose first seven bits, in arrival order, are 0,0,1,1,1,1,1; the last three bits can be anything. In word terms this is `rx_word[6:0] == 7'b1111100`. The bench uses the K28.5 word 10'h17C. The inverted form (arrival 1,1,0,0,0,0,0, word 10'h283) is treated as plain data. With `align_en` high, `sync_det` is high for exactly the one cycle after the comma's tenth bit.
- R3: Byte clocks. `bclk0` and `bclk1` are always complementary. In steady state each holds a level for 10 bit clocks. `rx_valid` pulses only in a cycle where one of them has just risen, and successive words alternate between the two clocks.
- R4: No half period of either byte clock is ever shorter than 10 bit clocks. Realignment only lengthens the level that is currently high.
- R5: Realignment from the clock-1 half. If a misaligned comma completes while `bclk1` is high, that comma is not presented. `bclk1` stays high for 10 more bit clocks. The next word then leaves on `bclk0`, and a comma 20 bits after the first one leaves on a `bclk1` rising edge.
- R6: Realignment from the clock-0 half. If a misaligned comma completes while `bclk0` is high, that comma is not presented. `bclk0` stays high for 10 more bit clocks, and the next word leaves on `bclk1`. The next comma, 20 bits later, is then also withheld and `bclk1` is stretched. From there on, commas leave on `bclk1`.
- R7: With `align_en` low, a comma is passed through as ordinary data. `sync_det` stays low and the byte-clock timing is unchanged.
- R8: While `sig_present` is low, `rx_word` reads 10'h3FF. Capture and `rx_valid` carry on regardless. When `sig_present` goes high again, `rx_word` shows the last captured word.
- R9: Reset state: `rx_word` is 10'h3FF, `rx_valid` and `sync_det` are low, `bclk1` is high and `bclk0` is low. The first word is presented on `bclk0` after ten bits, and `rx_word` reads all ones until then.
- R10: A comma that completes exactly on a `bclk1` boundary is presented as a normal word, with a `sync_det` pulse and no stretch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Recovered bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bit | input | 1 | Retimed serial data bit |
| sig_present | input | 1 | High while the line carries a usable signal |
| align_en | input | 1 | Enables comma search, realignment and `sync_det` |
| rx_word | output | 10 | Recovered word, first-arrived bit in bit 0 |
| rx_valid | output | 1 | One-cycle pulse when a new word is presented |
| bclk0 | output | 1 | Byte clock 0, half word rate, carries odd-position words |
| bclk1 | output | 1 | Byte clock 1, complement of `bclk0`, carries commas |
| sync_det | output | 1 | One-cycle pulse after an enabled comma is recognised |

## Verification
The hardest corner is a comma that completes while `bclk0` is high. A design that jumps straight to clock 1 would produce a short half period. A design that only stretches once would leave commas on `bclk0` indefinitely. The bench covers both realignment halves, checking the held levels in the middle of each stretch and the cycle in which alignment converges. It also sends the inverted comma as data: a design that matched both disparities would drop that word and pulse `sync_det`. The remaining checks cover commas with `align_en` low that land mid-word, where a leaky enable would shift the boundary, and `sig_present` dropping while words keep being captured.

// File: rtl/cad_pkg.sv
package cad_pkg;

  // Default geometry of the recovered word and of the comma prefix.
  localparam int unsigned CAD_WORD_W  = 10;
  localparam int unsigned CAD_COMMA_W = 7;

  // Comma prefix in window order: bit 0 is the earliest-arrived bit.
  // Arrival 0,0,1,1,1,1,1 maps to 7'b1111100.
  localparam logic [CAD_COMMA_W-1:0] CAD_COMMA_POS = 7'b1111100;

  // What the phase counter does in a given bit-clock cycle.
  typedef enum logic [1:0] {
    PH_STEP     = 2'd0,  // advance by one
    PH_WRAP     = 2'd1,  // end of the two-word period, back to zero
    PH_HOLD_HI1 = 2'd2,  // realign, keep clock 1 high for a full word more
    PH_HOLD_HI0 = 2'd3   // realign, keep clock 0 high for a full word more
  } cad_phase_act_e;

endpackage

// File: rtl/cad_shifter.sv
module cad_shifter #(
  parameter int unsigned WORD_W = cad_pkg::CAD_WORD_W
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              ser_bit,
  output logic [WORD_W-1:0] win
);

  // Newest bit enters at the top, so after WORD_W shifts the oldest bit
  // of the window sits in bit 0.
  logic [WORD_W-1:0] sr_q;

  assign win = {ser_bit, sr_q[WORD_W-1:1]};

  // All-ones reset keeps stale zeros from forming a comma prefix.
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '1;
    end else begin
      sr_q <= win;
    end
  end

endmodule

// File: rtl/cad_comma_match.sv
module cad_comma_match #(
  parameter int unsigned              COMMA_W   = cad_pkg::CAD_COMMA_W,
  parameter logic [COMMA_W-1:0]       COMMA_PAT = cad_pkg::CAD_COMMA_POS
) (
  input  logic               clk_bit,
  input  logic               rst_n,
  input  logic               align_en,
  input  logic [COMMA_W-1:0] prefix,
  output logic               hit,
  output logic               sync_det
);

  logic [COMMA_W-1:0] bit_eq;

  for (genvar i = 0; i < COMMA_W; i++) begin : g_cmp
    assign bit_eq[i] = (prefix[i] == COMMA_PAT[i]);
  end

  assign hit = &bit_eq;

  logic sync_q;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
    end else begin
      sync_q <= align_en & hit;
    end
  end

  assign sync_det = sync_q;

endmodule

// File: rtl/cad_phase_gen.sv
module cad_phase_gen
  import cad_pkg::*;
#(
  parameter int unsigned WORD_W = cad_pkg::CAD_WORD_W
) (
  input  logic clk_bit,
  input  logic rst_n,
  input  logic hit,
  input  logic align_en,
  output logic emit,
  output logic bclk0,
  output logic bclk1
);

  localparam int unsigned HALF   = WORD_W;
  localparam int unsigned PERIOD = 2 * WORD_W;
  localparam int unsigned PW     = $clog2(PERIOD);

  localparam logic [PW-1:0] P_MID  = PW'(HALF - 1);
  localparam logic [PW-1:0] P_END  = PW'(PERIOD - 1);
  localparam logic [PW-1:0] P_HALF = PW'(HALF);

  logic [PW-1:0]  p_q, p_d;
  logic           bclk1_q;
  logic           at_mid, at_end, in_hi1;
  cad_phase_act_e act;

  assign at_mid = (p_q == P_MID);
  assign at_end = (p_q == P_END);
  assign in_hi1 = (p_q < P_HALF);

  // A comma already ending on the clock-1 boundary needs no move.
  always_comb begin
    if (align_en && hit && !at_end) begin
      act = in_hi1 ? PH_HOLD_HI1 : PH_HOLD_HI0;
    end else if (at_end) begin
      act = PH_WRAP;
    end else begin
      act = PH_STEP;
    end
  end

  always_comb begin
    unique case (act)
      PH_HOLD_HI1: p_d = '0;
      PH_HOLD_HI0: p_d = P_HALF;
      PH_WRAP:     p_d = '0;
      default:     p_d = p_q + 1'b1;
    endcase
  end

  assign emit = (at_mid || at_end) &&
                (act != PH_HOLD_HI1) && (act != PH_HOLD_HI0);

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      p_q     <= '0;
      bclk1_q <= 1'b1;
    end else begin
      p_q     <= p_d;
      bclk1_q <= (p_d < P_HALF);
    end
  end

  assign bclk1 = bclk1_q;
  assign bclk0 = ~bclk1_q;

endmodule

// File: rtl/cad_word_out.sv
module cad_word_out #(
  parameter int unsigned WORD_W = cad_pkg::CAD_WORD_W
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              emit,
  input  logic [WORD_W-1:0] win,
  input  logic              sig_present,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '1;
      valid_q <= 1'b0;
    end else begin
      valid_q <= emit;
      if (emit) begin
        word_q <= win;
      end
    end
  end

  // Loss of signal masks the held word without disturbing capture.
  assign rx_word  = sig_present ? word_q : '1;
  assign rx_valid = valid_q;

endmodule

// File: rtl/comma_align_deser.sv
module comma_align_deser #(
  parameter int unsigned        WORD_W    = cad_pkg::CAD_WORD_W,
  parameter int unsigned        COMMA_W   = cad_pkg::CAD_COMMA_W,
  parameter logic [COMMA_W-1:0] COMMA_PAT = cad_pkg::CAD_COMMA_POS
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              ser_bit,
  input  logic              sig_present,
  input  logic              align_en,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              bclk0,
  output logic              bclk1,
  output logic              sync_det
);

  logic [WORD_W-1:0] win;
  logic              hit;
  logic              emit;

  cad_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk_bit (clk_bit),
    .rst_n   (rst_n),
    .ser_bit (ser_bit),
    .win     (win)
  );

  cad_comma_match #(.COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) u_match (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .align_en (align_en),
    .prefix   (win[COMMA_W-1:0]),
    .hit      (hit),
    .sync_det (sync_det)
  );

  cad_phase_gen #(.WORD_W(WORD_W)) u_phase (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .hit      (hit),
    .align_en (align_en),
    .emit     (emit),
    .bclk0    (bclk0),
    .bclk1    (bclk1)
  );

  cad_word_out #(.WORD_W(WORD_W)) u_out (
    .clk_bit     (clk_bit),
    .rst_n       (rst_n),
    .emit        (emit),
    .win         (win),
    .sig_present (sig_present),
    .rx_word     (rx_word),
    .rx_valid    (rx_valid)
  );

endmodule

// File: rtl/cad_checker.sv
module cad_checker #(
  parameter int unsigned WORD_W = cad_pkg::CAD_WORD_W
) (
  input logic              clk_bit,
  input logic              rst_n,
  input logic              align_en,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_valid,
  input logic              bclk0,
  input logic              bclk1,
  input logic              sync_det
);

  localparam int unsigned CW = $clog2(4 * WORD_W + 1);

  logic [CW-1:0] run_q;
  logic          last_q;
  logic          seen_q;

  // Length of the current byte-clock level, saturating.
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b1;
      seen_q <= 1'b0;
    end else begin
      if (bclk1 != last_q) begin
        run_q  <= CW'(1);
        last_q <= bclk1;
      end else if (run_q != '1) begin
        run_q <= run_q + 1'b1;
      end
      if (rx_valid) begin
        seen_q <= 1'b1;
      end
    end
  end

  a_r4_min_half: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (bclk1 != last_q) |-> (run_q >= CW'(WORD_W)));

  a_r3_valid_on_rise: assert property (@(posedge clk_bit) disable iff (!rst_n)
    rx_valid |-> ($rose(bclk0) || $rose(bclk1)));

  a_r7_quiet_when_off: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !align_en |=> !sync_det);

  a_r2_single_pulse: assert property (@(posedge clk_bit) disable iff (!rst_n)
    sync_det |=> !sync_det);

  a_r9_ones_before_first: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (!seen_q && !rx_valid) |-> (rx_word == '1));

endmodule

bind comma_align_deser cad_checker #(.WORD_W(WORD_W)) u_cad_checker (
  .clk_bit  (clk_bit),
  .rst_n    (rst_n),
  .align_en (align_en),
  .rx_word  (rx_word),
  .rx_valid (rx_valid),
  .bclk0    (bclk0),
  .bclk1    (bclk1),
  .sync_det (sync_det)
);

// File: tb/comma_align_deser_bench.sv
module comma_align_deser_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] KCH = 10'h17C;  // positive-disparity comma word

  // Table entry: {word, expect clock-1 rise, expect sync pulse}
  localparam int NTAB = 9;
  localparam logic [11:0] TAB [NTAB] = '{
    {KCH,    1'b1, 1'b1},
    {10'h155, 1'b0, 1'b0},
    {10'h333, 1'b1, 1'b0},
    {10'h283, 1'b0, 1'b0},
    {KCH,    1'b1, 1'b1},
    {10'h0CC, 1'b0, 1'b0},
    {KCH,    1'b1, 1'b1},
    {10'h249, 1'b0, 1'b0},
    {10'h2AA, 1'b1, 1'b0}
  };

  logic       clk_bit = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_bit = 1'b1;
  logic       sig_present = 1'b1;
  logic       align_en = 1'b1;
  logic [9:0] rx_word;
  logic       rx_valid, bclk0, bclk1, sync_det;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk_bit = ~clk_bit;

  comma_align_deser u_comma_align_deser (
    .clk_bit     (clk_bit),
    .rst_n       (rst_n),
    .ser_bit     (ser_bit),
    .sig_present (sig_present),
    .align_en    (align_en),
    .rx_word     (rx_word),
    .rx_valid    (rx_valid),
    .bclk0       (bclk0),
    .bclk1       (bclk1),
    .sync_det    (sync_det)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one bit just after an edge, then sample just after the next edge.
  task automatic put_bit(input logic b);
    ser_bit = b;
    @(posedge clk_bit);
    #1;
  endtask

  task automatic put_word(input logic [9:0] w, input int n);
    for (int i = 0; i < n; i++) put_bit(w[i]);
  endtask

  task automatic put_ones(input int n);
    for (int i = 0; i < n; i++) put_bit(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_bit);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_bit);
    #1;
    chk("R9 reset word", rx_word, 10'h3FF);
    chk("R9 reset valid", rx_valid, 0);
    chk("R9 reset bclk1", bclk1, 1);
    chk("R9 reset bclk0", bclk0, 0);
    chk("R9 reset sync", sync_det, 0);
    rst_n = 1'b1;

    // Phase A: comma while clock 1 is high (R5)
    put_ones(10);
    chk("R9 first word valid", rx_valid, 1);
    chk("R9 first word on bclk0", bclk0, 1);
    chk("R9 first word ones", rx_word, 10'h3FF);
    put_ones(3);
    put_word(KCH, 10);
    chk("R2 sync after comma", sync_det, 1);
    chk("R5 comma withheld", rx_valid, 0);
    chk("R5 bclk1 held", bclk1, 1);
    put_word(10'h2AA, 9);
    chk("R4 bclk1 still high in stretch", bclk1, 1);
    put_bit(1'b1);
    chk("R5 word after comma valid", rx_valid, 1);
    chk("R1 word after comma", rx_word, 10'h2AA);
    chk("R5 word after comma on bclk0", bclk0, 1);

    // Aligned stream from the table (R1, R2, R3, R10)
    for (int t = 0; t < NTAB; t++) begin
      put_word(TAB[t][11:2], 10);
      chk("R3 table valid", rx_valid, 1);
      chk("R1 table word", rx_word, TAB[t][11:2]);
      chk("R3 R10 table clock", bclk1, TAB[t][1]);
      chk("R2 table sync", sync_det, TAB[t][0]);
    end

    // Phase B: loss of signal (R8)
    sig_present = 1'b0;
    #1;
    chk("R8 forced ones", rx_word, 10'h3FF);
    put_word(10'h155, 10);
    chk("R8 capture continues", rx_valid, 1);
    chk("R8 still ones", rx_word, 10'h3FF);
    sig_present = 1'b1;
    #1;
    chk("R8 held word returns", rx_word, 10'h155);
    put_word(10'h333, 10);
    chk("R1 word after restore", rx_word, 10'h333);

    // Phase C: comma mid-word with alignment disabled (R7)
    align_en = 1'b0;
    put_ones(5);
    put_word(KCH, 5);
    chk("R7 boundary word", rx_word, 10'h39F);
    chk("R7 boundary on bclk0", bclk0, 1);
    put_word(KCH >> 5, 5);
    chk("R7 no sync", sync_det, 0);
    chk("R7 no clock move", bclk0, 1);
    put_ones(5);
    chk("R7 timing kept valid", rx_valid, 1);
    chk("R7 comma as data", rx_word, 10'h3EB);
    chk("R7 timing kept bclk1", bclk1, 1);

    // Phase D: comma while clock 0 is high (R6)
    align_en = 1'b1;
    put_ones(3);
    put_word(KCH, 7);
    chk("R6 pre word", rx_word, 10'h3E7);
    put_word(KCH >> 7, 3);
    chk("R6 sync", sync_det, 1);
    chk("R6 comma withheld", rx_valid, 0);
    chk("R6 bclk0 held", bclk0, 1);
    put_word(10'h155, 7);
    chk("R4 bclk0 still high in stretch", bclk0, 1);
    put_word(10'h155 >> 7, 3);
    chk("R6 next word valid", rx_valid, 1);
    chk("R6 next word", rx_word, 10'h155);
    chk("R6 next word on bclk1", bclk1, 1);
    put_word(KCH, 10);
    chk("R6 second comma withheld", rx_valid, 0);
    chk("R6 bclk1 stretched", bclk1, 1);
    chk("R6 second sync", sync_det, 1);
    put_word(10'h333, 10);
    chk("R6 data on bclk0", bclk0, 1);
    chk("R6 data word", rx_word, 10'h333);
    put_word(KCH, 10);
    chk("R6 converged valid", rx_valid, 1);
    chk("R6 converged on bclk1", bclk1, 1);
    chk("R10 comma presented", rx_word, KCH);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule